// File: doc/BRIEF.md
# Coherent 64-bit Timestamp Reader

This block fetches a free-running 64-bit timestamp that lives behind a 32-bit register read port as two halves. The counter keeps ticking, and it can jump, while the two halves are fetched. A torn value is avoided by reading the upper half first. The block then repeats a pair of reads, lower half then upper half, until the upper half stops moving. The number of repeats is bounded. If the upper half never settles, the block returns its last sample and raises a warning flag.

The same sequencer also drives the two other timestamp operations over the shared port. A load writes the lower half first and then the upper half. A counter clear writes a control word with a single clear bit set, and it writes that word twice so that the toggle inside the counter does not stay armed for a later chip reset.

A client pulses one of three start inputs. It then waits for `busy` to fall, and for reads it also waits for the one-cycle `result_valid` pulse.

Top module: `tsf_coherent_reader`

## Requirements
- R1: After reset `busy`, `bus_req`, `result_valid` and `retry_warn` are all 0.
- R2: A read makes its first access a read (`bus_we`=0) of `ADDR_HI`. It then alternates reads of `ADDR_LO` and `ADDR_HI`, each pair forming one attempt.
- R3: When the upper half read at the end of an attempt equals the upper half held from the previous read, the result is {held upper, lower of that attempt}, `retry_warn` is 0, and no further access is made.
- R4: When that comparison fails, the newly read upper half becomes the held value and another attempt follows. The next comparison is made against the newest value, not the first one.
- R5: At most `MAX_TRIES` (default 10) attempts are made. If the last one also fails, the result is {last upper read, last lower read} and `retry_warn` is 1. `retry_warn` holds until the next read completes. A match on the final attempt still counts as success.
- R6: A load writes `wr_value[31:0]` to `ADDR_LO` and then `wr_value[63:32]` to `ADDR_HI`, with exactly two accesses.
- R7: A clear makes exactly two writes to `ADDR_CTL`. Each write carries the data word with only bit `RST_BIT` (default 24) set.
- R8: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` keep their values into the next cycle. There is never more than one access in flight.
- R9: Start pulses that arrive while `busy` is high are ignored and cause no access. When several starts arrive together while idle, read wins over load, and load wins over clear.
- R10: `busy` rises in the cycle after an accepted start and falls in the cycle after the final acknowledge. `result_valid` is a one-cycle pulse in the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_start | input | 1 | Start a coherent read |
| wr_start | input | 1 | Start a 64-bit load |
| wr_value | input | 64 | Value to load, sampled with `wr_start` |
| tsf_rst_start | input | 1 | Start a counter clear |
| busy | output | 1 | An operation is in progress |
| result_valid | output | 1 | One-cycle pulse: `result` holds a new read value |
| result | output | 64 | Last coherent read value |
| retry_warn | output | 1 | Last read ran out of attempts |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access done; read data valid in this cycle |
| bus_rdata | input | 32 | Read data |

## Verification
Each access completes at the clock edge where `bus_req` and `bus_ack` are both high. The next access is already presented in the following cycle. A read therefore finishes in the cycle after its last acknowledge, and `result_valid` and the fall of `busy` appear together in that same cycle. The bench drives starts and the acknowledge at the falling edge. It samples `result`, `retry_warn` and `busy` at the first falling edge where `result_valid` is seen, and it records every acknowledged access with its direction, address and data. Access counts and order are then compared against what the requirement predicts for the scripted upper-half sequence: 3 accesses for a stable read, 5 for one retry, and 21 for ten attempts.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HI0,
        ST_RD_LO,
        ST_RD_HI1,
        ST_WR_LO,
        ST_WR_HI,
        ST_CLR_A,
        ST_CLR_B
    } tsf_state_e;
endpackage

// File: rtl/tsf_try_counter.sv
module tsf_try_counter #(
    parameter int MAX_TRIES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(MAX_TRIES - 1));
endmodule

// File: rtl/tsf_cmd_map.sv
module tsf_cmd_map
    import tsf_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  ADDR_LO  = 8'h20,
    parameter logic [7:0]  ADDR_HI  = 8'h24,
    parameter logic [7:0]  ADDR_CTL = 8'h28,
    parameter int          RST_BIT  = 24
) (
    input  tsf_state_e         state,
    input  logic [DATA_W-1:0]  ld_lo,
    input  logic [DATA_W-1:0]  ld_hi,
    output logic               req,
    output logic               we,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  wdata
);
    localparam logic [DATA_W-1:0] CLR_WORD = DATA_W'(1) << RST_BIT;

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (state)
            ST_RD_HI0, ST_RD_HI1: addr = ADDR_W'(ADDR_HI);
            ST_RD_LO:             addr = ADDR_W'(ADDR_LO);
            ST_WR_LO: begin
                we    = 1'b1;
                addr  = ADDR_W'(ADDR_LO);
                wdata = ld_lo;
            end
            ST_WR_HI: begin
                we    = 1'b1;
                addr  = ADDR_W'(ADDR_HI);
                wdata = ld_hi;
            end
            ST_CLR_A, ST_CLR_B: begin
                we    = 1'b1;
                addr  = ADDR_W'(ADDR_CTL);
                wdata = CLR_WORD;
            end
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsf_coherent_reader.sv
module tsf_coherent_reader
    import tsf_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  ADDR_LO   = 8'h20,
    parameter logic [7:0]  ADDR_HI   = 8'h24,
    parameter logic [7:0]  ADDR_CTL  = 8'h28,
    parameter int          RST_BIT   = 24,
    parameter int          MAX_TRIES = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_start,
    input  logic                  wr_start,
    input  logic [2*DATA_W-1:0]   wr_value,
    input  logic                  tsf_rst_start,
    output logic                  busy,
    output logic                  result_valid,
    output logic [2*DATA_W-1:0]   result,
    output logic                  retry_warn,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_ack,
    input  logic [DATA_W-1:0]     bus_rdata
);
    localparam int TW = 2 * DATA_W;

    typedef struct packed {
        tsf_state_e         state;
        logic [DATA_W-1:0]  hi;
        logic [DATA_W-1:0]  lo;
        logic [TW-1:0]      ld;
        logic [TW-1:0]      res;
        logic               valid;
        logic               warn;
    } reg_t;

    reg_t r_d, r_q;
    logic try_clr, try_inc, try_last;

    tsf_try_counter #(.MAX_TRIES(MAX_TRIES)) i_tries (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (try_clr),
        .inc  (try_inc),
        .last (try_last)
    );

    tsf_cmd_map #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO),
        .ADDR_HI(ADDR_HI), .ADDR_CTL(ADDR_CTL), .RST_BIT(RST_BIT)
    ) i_map (
        .state(r_q.state),
        .ld_lo(r_q.ld[DATA_W-1:0]),
        .ld_hi(r_q.ld[TW-1:DATA_W]),
        .req  (bus_req),
        .we   (bus_we),
        .addr (bus_addr),
        .wdata(bus_wdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        try_clr   = 1'b0;
        try_inc   = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (rd_start) begin
                    r_d.state = ST_RD_HI0;
                    try_clr   = 1'b1;
                end else if (wr_start) begin
                    r_d.state = ST_WR_LO;
                    r_d.ld    = wr_value;
                end else if (tsf_rst_start) begin
                    r_d.state = ST_CLR_A;
                end
            end
            ST_RD_HI0: if (bus_ack) begin
                r_d.hi    = bus_rdata;
                r_d.state = ST_RD_LO;
            end
            ST_RD_LO: if (bus_ack) begin
                r_d.lo    = bus_rdata;
                r_d.state = ST_RD_HI1;
            end
            ST_RD_HI1: if (bus_ack) begin
                r_d.hi = bus_rdata;
                if (bus_rdata == r_q.hi) begin
                    r_d.res   = {r_q.hi, r_q.lo};
                    r_d.valid = 1'b1;
                    r_d.warn  = 1'b0;
                    r_d.state = ST_IDLE;
                end else if (try_last) begin
                    r_d.res   = {bus_rdata, r_q.lo};
                    r_d.valid = 1'b1;
                    r_d.warn  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    try_inc   = 1'b1;
                    r_d.state = ST_RD_LO;
                end
            end
            ST_WR_LO: if (bus_ack) r_d.state = ST_WR_HI;
            ST_WR_HI: if (bus_ack) r_d.state = ST_IDLE;
            ST_CLR_A: if (bus_ack) r_d.state = ST_CLR_B;
            ST_CLR_B: if (bus_ack) r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.state != ST_IDLE);
    assign result_valid = r_q.valid;
    assign result       = r_q.res;
    assign retry_warn   = r_q.warn;
endmodule

// File: rtl/tsf_reader_checker.sv
module tsf_reader_checker #(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  ADDR_LO   = 8'h20,
    parameter logic [7:0]  ADDR_CTL  = 8'h28,
    parameter int          RST_BIT   = 24,
    parameter int          MAX_TRIES = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_start,
    input logic               wr_start,
    input logic               tsf_rst_start,
    input logic               busy,
    input logic               result_valid,
    input logic               retry_warn,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_ack
);
    localparam int CW = $clog2(MAX_TRIES + 2);
    logic [CW-1:0] lo_reads;

    // Count lower-half reads inside the current operation (window check for R5).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_reads <= '0;
        end else if (!busy) begin
            lo_reads <= '0;
        end else if (bus_req && bus_ack && !bus_we && bus_addr == ADDR_W'(ADDR_LO)
                     && lo_reads != '1) begin
            lo_reads <= lo_reads + 1'b1;
        end
    end

    assert_attempt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_reads <= CW'(MAX_TRIES));

    assert_warn_with_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_warn) |-> result_valid);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    assert_clear_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_W'(ADDR_CTL))
            |-> (bus_wdata == (DATA_W'(1) << RST_BIT)));

    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rd_start && !wr_start && !tsf_rst_start) |=> !bus_req);

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !busy);

    assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(rd_start || wr_start || tsf_rst_start));
endmodule

bind tsf_coherent_reader tsf_reader_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO),
    .ADDR_CTL(ADDR_CTL), .RST_BIT(RST_BIT), .MAX_TRIES(MAX_TRIES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .wr_start(wr_start),
    .tsf_rst_start(tsf_rst_start), .busy(busy), .result_valid(result_valid),
    .retry_warn(retry_warn), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/test_tsf_coherent_reader.sv
module test_tsf_coherent_reader;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0]  A_LO  = 8'h20;
    localparam logic [7:0]  A_HI  = 8'h24;
    localparam logic [7:0]  A_CTL = 8'h28;
    localparam logic [31:0] LO_BASE = 32'hA000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_start = 1'b0, wr_start = 1'b0, tsf_rst_start = 1'b0;
    logic [63:0] wr_value = '0;
    logic        busy, result_valid, retry_warn;
    logic [63:0] result;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // bus model state
    int          lat = 0;
    int          wait_cnt = 0;
    int          hi_idx = 0, lo_idx = 0, n_log = 0;
    logic [31:0] hi_seq [16];
    logic        log_we   [32];
    logic [7:0]  log_addr [32];
    logic [31:0] log_data [32];

    logic [63:0] got_res;
    logic        got_warn, got_busy;

    tsf_coherent_reader i_tsf_coherent_reader (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .wr_start(wr_start),
        .wr_value(wr_value), .tsf_rst_start(tsf_rst_start), .busy(busy),
        .result_valid(result_valid), .result(result), .retry_warn(retry_warn),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register-port model: acknowledges after lat idle falling edges, logs each access.
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
            wait_cnt = 0;
        end else if (bus_req) begin
            if (wait_cnt >= lat) begin
                bus_ack = 1'b1;
                wait_cnt = 0;
                if (n_log < 32) begin
                    log_we[n_log]   = bus_we;
                    log_addr[n_log] = bus_addr;
                    log_data[n_log] = bus_wdata;
                end
                n_log++;
                if (!bus_we && bus_addr == A_HI) begin
                    bus_rdata = hi_seq[(hi_idx < 16) ? hi_idx : 15];
                    hi_idx++;
                end else if (!bus_we) begin
                    bus_rdata = LO_BASE + 32'(lo_idx);
                    lo_idx++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_log = 0; hi_idx = 0; lo_idx = 0;
    endtask

    task automatic pulse(input bit r, input bit w, input bit c);
        @(negedge clk);
        rd_start = r; wr_start = w; tsf_rst_start = c;
        @(negedge clk);
        rd_start = 0; wr_start = 0; tsf_rst_start = 0;
    endtask

    task automatic wait_done(input bit want_valid);
        bit seen = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (want_valid ? result_valid : !busy) begin
                seen = 1;
                got_res = result; got_warn = retry_warn; got_busy = busy;
            end
        end
        if (!seen) chk(0, "timeout R10", 0, 1);
    endtask

    task automatic t_reset();
        chk(busy == 0, "R1 busy", 64'(busy), 0);
        chk(bus_req == 0, "R1 bus_req", 64'(bus_req), 0);
        chk(result_valid == 0, "R1 result_valid", 64'(result_valid), 0);
        chk(retry_warn == 0, "R1 retry_warn", 64'(retry_warn), 0);
    endtask

    task automatic t_stable(input int l);
        lat = l; clear_log();
        hi_seq[0] = 32'h0000_1234; hi_seq[1] = 32'h0000_1234;
        pulse(1, 0, 0);
        chk(busy == 1, "R10 busy after start", 64'(busy), 1);
        wait_done(1);
        chk(got_res == {32'h0000_1234, LO_BASE}, "R3 stable result", got_res,
            {32'h0000_1234, LO_BASE});
        chk(got_warn == 0, "R3 warn", 64'(got_warn), 0);
        chk(got_busy == 0, "R10 busy falls with valid", 64'(got_busy), 0);
        chk(n_log == 3, "R3 access count", 64'(n_log), 3);
        chk(!log_we[0] && log_addr[0] == A_HI && log_addr[1] == A_LO && log_addr[2] == A_HI,
            "R2 order", {log_addr[0], log_addr[1], log_addr[2]}, {A_HI, A_LO, A_HI});
        @(negedge clk);
        chk(result_valid == 0, "R10 valid one cycle", 64'(result_valid), 0);
    endtask

    task automatic t_one_retry();
        lat = 1; clear_log();
        hi_seq[0] = 32'h10; hi_seq[1] = 32'h11; hi_seq[2] = 32'h11;
        pulse(1, 0, 0); wait_done(1);
        chk(got_res == {32'h11, LO_BASE + 32'd1}, "R4 retry result", got_res,
            {32'h11, LO_BASE + 32'd1});
        chk(n_log == 5, "R4 access count", 64'(n_log), 5);
        chk(got_warn == 0, "R4 warn", 64'(got_warn), 0);
    endtask

    task automatic t_exhaust();
        lat = 0; clear_log();
        for (int k = 0; k < 16; k++) hi_seq[k] = 32'h100 + 32'(k);
        pulse(1, 0, 0); wait_done(1);
        chk(got_res == {32'h10A, LO_BASE + 32'd9}, "R5 exhaust result", got_res,
            {32'h10A, LO_BASE + 32'd9});
        chk(got_warn == 1, "R5 warn set", 64'(got_warn), 1);
        chk(n_log == 21, "R5 access count", 64'(n_log), 21);
        repeat (3) @(negedge clk);
        chk(retry_warn == 1, "R5 warn held", 64'(retry_warn), 1);
    endtask

    task automatic t_last_try_ok();
        lat = 0; clear_log();
        for (int k = 0; k < 16; k++) hi_seq[k] = 32'h200 + 32'(k);
        hi_seq[10] = hi_seq[9];
        pulse(1, 0, 0); wait_done(1);
        chk(got_res == {32'h209, LO_BASE + 32'd9}, "R5 final attempt match", got_res,
            {32'h209, LO_BASE + 32'd9});
        chk(got_warn == 0, "R5 warn cleared", 64'(got_warn), 0);
        chk(n_log == 21, "R5 final attempt count", 64'(n_log), 21);
    endtask

    task automatic t_load();
        lat = 2; clear_log();
        wr_value = 64'h1122_3344_5566_7788;
        pulse(0, 1, 0); wait_done(0);
        chk(n_log == 2, "R6 access count", 64'(n_log), 2);
        chk(log_we[0] && log_addr[0] == A_LO && log_data[0] == 32'h5566_7788,
            "R6 low first", {log_addr[0], log_data[0]}, {A_LO, 32'h5566_7788});
        chk(log_we[1] && log_addr[1] == A_HI && log_data[1] == 32'h1122_3344,
            "R6 high second", {log_addr[1], log_data[1]}, {A_HI, 32'h1122_3344});
    endtask

    task automatic t_clear();
        lat = 1; clear_log();
        pulse(0, 0, 1); wait_done(0);
        chk(n_log == 2, "R7 access count", 64'(n_log), 2);
        for (int k = 0; k < 2; k++)
            chk(log_we[k] && log_addr[k] == A_CTL && log_data[k] == 32'h0100_0000,
                "R7 clear write", {log_addr[k], log_data[k]}, {A_CTL, 32'h0100_0000});
    endtask

    task automatic t_ignore_busy();
        lat = 3; clear_log();
        hi_seq[0] = 32'h55; hi_seq[1] = 32'h55;
        pulse(1, 0, 0);
        pulse(0, 1, 1);
        pulse(1, 0, 0);
        wait_done(1);
        repeat (4) @(negedge clk);
        chk(n_log == 3, "R9 starts while busy ignored", 64'(n_log), 3);
        chk(busy == 0, "R9 stays idle", 64'(busy), 0);
    endtask

    task automatic t_priority();
        lat = 0; clear_log();
        hi_seq[0] = 32'h77; hi_seq[1] = 32'h77;
        pulse(1, 1, 1); wait_done(1);
        repeat (3) @(negedge clk);
        chk(n_log == 3 && !log_we[0] && log_addr[0] == A_HI, "R9 read wins",
            {log_addr[0], 24'(n_log)}, {A_HI, 24'd3});
        clear_log();
        pulse(0, 1, 1); wait_done(0);
        chk(n_log == 2 && log_addr[0] == A_LO && log_addr[1] == A_HI, "R9 load beats clear",
            {log_addr[0], log_addr[1]}, {A_LO, A_HI});
    endtask

    task automatic t_hold();
        lat = 4; clear_log();
        hi_seq[0] = 32'h9; hi_seq[1] = 32'h9;
        pulse(1, 0, 0);
        chk(bus_req && bus_addr == A_HI, "R8 request presented",
            64'(bus_addr), 64'(A_HI));
        repeat (3) @(negedge clk);
        chk(bus_req && bus_addr == A_HI && !bus_we, "R8 request held",
            64'(bus_addr), 64'(A_HI));
        wait_done(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_stable(0);
        t_stable(2);
        t_one_retry();
        t_exhaust();
        t_last_try_ok();
        t_load();
        t_clear();
        t_ignore_busy();
        t_priority();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(0, "watchdog R10", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule